// File: doc/BRIEF.md
# One-Bounded Token Net Sequencer

This block runs a small, safe (one-bounded) token net in logic. Each place is a single marking bit, and the whole net is re-evaluated on every clock edge, which is one evaluation cycle. A transition becomes eligible when three things hold: its selected guard input is high, any timer attached to it has expired, and every one of its input places is marked. When it fires, its input places are cleared and its output places are set. All firings in one cycle are applied together at the clock edge.

The net's structure is fixed by parameters. These are per-transition input and output place masks, a guard selector for each transition, an initial marking, timer-to-place and timer-to-transition maps, output OR masks, and a list of monitored places. A pulse on the init input reloads the initial marking and clears every timer. The block is meant to sit next to plant I/O as a hardware sequencer. Its registered outputs drive actuators, and a 4-bit debug code tells which monitored place holds the token.

The default net has six places and eight transitions. Place 0 is a scan state left by guard 0 (to place 1) or by timeout (to place 2). Place 1 returns to place 0 on guard 1. Place 2 is a second scan state left by guard 0 (to place 3) or by timeout (back to place 0). Place 3 returns to place 2 on guard 1. Places 4 and 5 form a separate loop, toggled by guard 2 (4 to 5) and guard 3 (5 to 4).

Top module: `pn_engine`

## Requirements
- R1: A synchronous high `rst`, or a high `init_i`, loads the initial marking on the next edge (default 6'b010001: places 0 and 4) and clears every timer. Init takes precedence over any firing in the same cycle.
- R2: A transition fires only if its guard is high and all of its input places are marked. A guard selector equal to the guard count means the guard is always true. A high guard whose transition's input place is empty leaves `mark_o` unchanged.
- R3: Firing clears the transition's input places and sets its output places on `mark_o` after the next edge. Transitions that share no input place fire in the same cycle (default: guards 0 and 2 together move places 0,4 to places 1,5).
- R4: When enabled transitions compete for one input place, only the lowest-indexed one fires. By default, guard 0 high in the cycle the place-0 timeout expires sends the token to place 1, not place 2.
- R5: A timer counts edges while its place is marked, saturates at TIMEOUT and returns to zero on any edge where the place is unmarked. Its transition may fire once the count equals TIMEOUT. A token placed at edge e therefore leaves at edge e+TIMEOUT+1 (default TIMEOUT=5, timers on places 0 and 2).
- R6: Each `out_o` bit is the OR of the marked places in its mask. Default masks: bit 0 = places 1 or 3, bit 1 = places 0 or 1, bit 2 = place 5.
- R7: `dbg_o` is 0 when no monitored place is marked, 4'hF when more than one is marked, and otherwise the 1-based position of the marked place in the monitored list. The default list is places 1, 2, 3, 5, giving codes 1, 2, 3, 4.
- R8: A token produced in one cycle cannot be consumed in that same cycle. With guards 0 and 1 both held high, the token alternates between places 0 and 1 on every edge.
- R9: `mark_o`, `out_o` and `dbg_o` are registered and change together on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge is one evaluation cycle |
| rst | input | 1 | Synchronous active-high reset to the initial marking |
| init_i | input | 1 | Reload initial marking and clear timers |
| guard_i | input | NG | External guard conditions |
| mark_o | output | NP | Current marking, one bit per place |
| out_o | output | NO | OR-combined place outputs |
| dbg_o | output | 4 | Monitored-place code (0 none, 4'hF several) |

## Verification
A wrong marking bit appears on `mark_o` at the first edge after the fault. It also reaches `out_o` and `dbg_o` in that same cycle, so a reference compare on every clock finds it at once. Timer faults are slower to show: a miscounting timer only shows up as a token leaving its place one edge too early or too late, so the bench checks the exact edge of departure. A priority fault shows up only when a guard and a timeout collide, and a lost or duplicated token shows as the debug code turning 4'hF or 0.

// File: rtl/pn_pkg.sv
package pn_pkg;
  localparam logic [3:0] DBG_NONE  = 4'h0;
  localparam logic [3:0] DBG_MULTI = 4'hF;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pn_timer.sv
module pn_timer #(
  parameter int TW      = 8,
  parameter int TIMEOUT = 5
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr || !run)          cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIMIT);

  // R5: idle place means the count restarts from zero
  a_r5_idle_clear: assert property (@(posedge clk) disable iff (clr)
    !run |=> (cnt_q == '0));
  // R5: count never passes the timeout
  a_r5_saturate: assert property (@(posedge clk) disable iff (clr)
    run |=> (cnt_q <= LIMIT));
endmodule

// File: rtl/pn_fire.sv
module pn_fire #(
  parameter int NP = 6,
  parameter int NT = 8,
  parameter logic [NT*NP-1:0] PRE  = '0,
  parameter logic [NT*NP-1:0] POST = '0
) (
  input  logic [NP-1:0] mark,
  input  logic [NT-1:0] allow,
  output logic [NT-1:0] fire,
  output logic [NP-1:0] mark_nxt
);
  logic [NP-1:0] claimed;
  logic [NP-1:0] made;

  // Lower index claims its input places first (R4); updates are collected
  // and applied as one new marking (R8).
  always_comb begin
    claimed = '0;
    made    = '0;
    fire    = '0;
    for (int t = 0; t < NT; t++) begin
      if (allow[t]
          && ((mark & PRE[t*NP +: NP]) == PRE[t*NP +: NP])
          && ((claimed & PRE[t*NP +: NP]) == '0)) begin
        fire[t] = 1'b1;
        claimed = claimed | PRE[t*NP +: NP];
        made    = made | POST[t*NP +: NP];
      end
    end
    mark_nxt = (mark & ~claimed) | made;
  end
endmodule

// File: rtl/pn_dbg_enc.sv
module pn_dbg_enc #(
  parameter int NP = 6,
  parameter int NM = 4,
  parameter int PW = 3,
  parameter logic [NM*PW-1:0] MON = '0
) (
  input  logic [NP-1:0] mark,
  output logic [3:0]    code
);
  int unsigned hits;
  int unsigned pos;

  always_comb begin
    hits = 0;
    pos  = 0;
    for (int k = 0; k < NM; k++) begin
      if (mark[MON[k*PW +: PW]]) begin
        hits = hits + 1;
        pos  = k + 1;
      end
    end
    if (hits == 0)     code = pn_pkg::DBG_NONE;
    else if (hits > 1) code = pn_pkg::DBG_MULTI;
    else               code = 4'(pos);
  end
endmodule

// File: rtl/pn_engine.sv
module pn_engine #(
  parameter int NP      = 6,
  parameter int NT      = 8,
  parameter int NG      = 4,
  parameter int NO      = 3,
  parameter int NTM     = 2,
  parameter int NM      = 4,
  parameter int TW      = 8,
  parameter int TIMEOUT = 5,
  localparam int PW  = pn_pkg::idx_w(NP),
  localparam int TIW = pn_pkg::idx_w(NT),
  localparam int GSW = $clog2(NG + 1),
  parameter logic [NT*NP-1:0] PRE_MASK =
    {6'b100000, 6'b010000, 6'b000100, 6'b001000,
     6'b000100, 6'b000001, 6'b000010, 6'b000001},
  parameter logic [NT*NP-1:0] POST_MASK =
    {6'b010000, 6'b100000, 6'b000001, 6'b000100,
     6'b001000, 6'b000100, 6'b000001, 6'b000010},
  parameter logic [NT*GSW-1:0] GUARD_SEL =
    {3'd3, 3'd2, 3'd4, 3'd1, 3'd0, 3'd4, 3'd1, 3'd0},
  parameter logic [NP-1:0]     INIT_MARK = 6'b010001,
  parameter logic [NO*NP-1:0]  OUT_MASK  = {6'b100000, 6'b000011, 6'b001010},
  parameter logic [NTM*PW-1:0] TMR_PLACE = {3'd2, 3'd0},
  parameter logic [NTM*TIW-1:0] TMR_TRANS = {3'd5, 3'd2},
  parameter logic [NM*PW-1:0]  MON_PLACE = {3'd5, 3'd3, 3'd2, 3'd1}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_i,
  input  logic [NG-1:0] guard_i,
  output logic [NP-1:0] mark_o,
  output logic [NO-1:0] out_o,
  output logic [3:0]    dbg_o
);
  logic          clr;
  logic [NP-1:0] mark_q, mark_nxt, mark_d;
  logic [NT-1:0] guard_ok, tmr_ok, allow, fire;
  logic [NTM-1:0] tmr_done;
  logic [NO-1:0] out_d;
  logic [3:0]    dbg_d;
  logic [NP-1:0] mon_mask;

  assign clr = rst | init_i;

  // guard selection; selector value NG means unconditional
  always_comb begin
    for (int t = 0; t < NT; t++) begin
      guard_ok[t] = (GUARD_SEL[t*GSW +: GSW] == GSW'(NG));
      for (int g = 0; g < NG; g++)
        if (GUARD_SEL[t*GSW +: GSW] == GSW'(g)) guard_ok[t] = guard_i[g];
    end
  end

  genvar k;
  generate
    for (k = 0; k < NTM; k++) begin : g_tmr
      pn_timer #(.TW(TW), .TIMEOUT(TIMEOUT)) u_tmr (
        .clk  (clk),
        .clr  (clr),
        .run  (mark_q[TMR_PLACE[k*PW +: PW]]),
        .done (tmr_done[k])
      );
    end
  endgenerate

  always_comb begin
    tmr_ok = '1;
    for (int j = 0; j < NTM; j++)
      for (int t = 0; t < NT; t++)
        if (TMR_TRANS[j*TIW +: TIW] == TIW'(t) && !tmr_done[j]) tmr_ok[t] = 1'b0;
  end

  assign allow = guard_ok & tmr_ok;

  pn_fire #(.NP(NP), .NT(NT), .PRE(PRE_MASK), .POST(POST_MASK)) u_fire (
    .mark     (mark_q),
    .allow    (allow),
    .fire     (fire),
    .mark_nxt (mark_nxt)
  );

  assign mark_d = clr ? INIT_MARK : mark_nxt;

  always_comb begin
    for (int o = 0; o < NO; o++) out_d[o] = |(mark_d & OUT_MASK[o*NP +: NP]);
  end

  pn_dbg_enc #(.NP(NP), .NM(NM), .PW(PW), .MON(MON_PLACE)) u_dbg (
    .mark (mark_d),
    .code (dbg_d)
  );

  always_ff @(posedge clk) begin
    mark_q <= mark_d;
    out_o  <= out_d;
    dbg_o  <= dbg_d;
  end

  assign mark_o = mark_q;

  always_comb begin
    mon_mask = '0;
    for (int j = 0; j < NM; j++) mon_mask[MON_PLACE[j*PW +: PW]] = 1'b1;
  end

  // R1: init reloads the initial marking
  a_r1_init_load: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (mark_o == INIT_MARK));

  // R7: several monitored places marked gives the error code
  a_r7_multi_code: assert property (@(posedge clk) disable iff (rst)
    ($countones(mark_o & mon_mask) > 1) |-> (dbg_o == pn_pkg::DBG_MULTI));
  a_r7_none_code: assert property (@(posedge clk) disable iff (rst)
    ((mark_o & mon_mask) == '0) |-> (dbg_o == pn_pkg::DBG_NONE));

  genvar t, p, o;
  generate
    for (t = 0; t < NT; t++) begin : g_chk_t
      // R2: firing needs guard/timer and full input places
      a_r2_enabled: assert property (@(posedge clk) disable iff (clr)
        fire[t] |-> (allow[t] && ((mark_q & PRE_MASK[t*NP +: NP]) == PRE_MASK[t*NP +: NP])));
    end
    for (p = 0; p < NP; p++) begin : g_chk_p
      logic [NT-1:0] takers;
      for (t = 0; t < NT; t++) begin : g_take
        assign takers[t] = PRE_MASK[t*NP + p];
      end
      // R4: at most one consumer of a place fires per cycle
      a_r4_one_taker: assert property (@(posedge clk) disable iff (clr)
        $onehot0(fire & takers));
    end
    for (o = 0; o < NO; o++) begin : g_chk_o
      // R6, R9: outputs track the registered marking in the same cycle
      a_r6_or_out: assert property (@(posedge clk) disable iff (rst)
        out_o[o] == |(mark_o & OUT_MASK[o*NP +: NP]));
    end
  endgenerate
endmodule

// File: tb/test_pn_engine.sv
`timescale 1ns/1ps
module test_pn_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_i = 1'b0;
  logic [3:0] guard_i = '0;
  logic [5:0] mark_o;
  logic [2:0] out_o;
  logic [3:0] dbg_o;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pn_engine i_pn_engine (
    .clk(clk), .rst(rst), .init_i(init_i), .guard_i(guard_i),
    .mark_o(mark_o), .out_o(out_o), .dbg_o(dbg_o)
  );

  // ---------------- behavioural reference ----------------
  int src_pl [8] = '{0, 1, 0, 2, 3, 2, 4, 5};
  int dst_pl [8] = '{1, 0, 2, 3, 2, 0, 5, 4};
  int gsel   [8] = '{0, 1, 4, 0, 1, 4, 2, 3};
  int t_place[2] = '{0, 2};
  int t_trans[2] = '{2, 5};
  int mon    [4] = '{1, 2, 3, 5};
  bit tok [6];
  int age [2];
  bit started = 0;

  always @(posedge clk) begin
    bit taken [6];
    bit add [6];
    bit ok;
    started = 1;
    if (rst || init_i) begin
      foreach (tok[i]) tok[i] = (i == 0 || i == 4);
      age[0] = 0; age[1] = 0;
    end else begin
      foreach (taken[i]) begin taken[i] = 0; add[i] = 0; end
      for (int t = 0; t < 8; t++) begin
        ok = tok[src_pl[t]] && (gsel[t] == 4 || guard_i[gsel[t]]);
        for (int j = 0; j < 2; j++)
          if (t_trans[j] == t && age[j] != 5) ok = 0;
        if (ok && !taken[src_pl[t]]) begin
          taken[src_pl[t]] = 1;
          add[dst_pl[t]] = 1;
        end
      end
      for (int j = 0; j < 2; j++)
        if (!tok[t_place[j]]) age[j] = 0;
        else if (age[j] < 5) age[j]++;
      foreach (tok[i]) tok[i] = (tok[i] && !taken[i]) || add[i];
    end
  end

  function automatic logic [5:0] exp_mark();
    logic [5:0] v;
    foreach (tok[i]) v[i] = tok[i];
    return v;
  endfunction

  function automatic logic [3:0] exp_dbg();
    int n = 0, pos = 0;
    for (int j = 0; j < 4; j++) if (tok[mon[j]]) begin n++; pos = j + 1; end
    if (n == 0) return 4'h0;
    if (n > 1) return 4'hF;
    return 4'(pos);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle compare against the reference (R3, R6, R7, R9)
  always @(negedge clk) begin
    if (started) begin
      chk("R3 model marking", 32'(mark_o), 32'(exp_mark()));
      chk("R6 model outputs", 32'(out_o),
          32'({tok[5], tok[0] | tok[1], tok[1] | tok[3]}));
      chk("R7 model debug", 32'(dbg_o), 32'(exp_dbg()));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    chk("R1 reset marking", 32'(mark_o), 32'h11);
    chk("R6 reset outputs", 32'(out_o), 32'h2);
    chk("R7 reset debug none", 32'(dbg_o), 32'h0);

    tick(5);
    chk("R5 token held until timeout", 32'(mark_o), 32'h11);
    tick(1);
    chk("R5 timeout moves p0 to p2", 32'(mark_o), 32'h14);
    chk("R7 single code p2", 32'(dbg_o), 32'h2);
    chk("R6 outputs idle", 32'(out_o), 32'h0);
    tick(5);
    chk("R5 p2 held", 32'(mark_o), 32'h14);
    tick(1);
    chk("R5 p2 timeout back to p0", 32'(mark_o), 32'h11);

    guard_i = 4'b1010;
    tick(3);
    chk("R2 guard with empty place ignored", 32'(mark_o), 32'h11);
    guard_i = 4'b0000;

    init_i = 1'b1;
    tick(1);
    init_i = 1'b0;
    tick(5);
    guard_i = 4'b0001;
    tick(1);
    chk("R4 lowest index wins on p0", 32'(mark_o), 32'h12);
    chk("R7 single code p1", 32'(dbg_o), 32'h1);
    chk("R9 outputs with marking", 32'(out_o), 32'h3);

    guard_i = 4'b0010;
    tick(1);
    chk("R3 release returns token", 32'(mark_o), 32'h11);

    guard_i = 4'b0101;
    tick(1);
    chk("R3 concurrent firing", 32'(mark_o), 32'h22);
    chk("R7 multi code", 32'(dbg_o), 32'hF);
    chk("R6 all outputs", 32'(out_o), 32'h7);

    guard_i = 4'b0011;
    tick(1);
    chk("R8 no chaining in one cycle", 32'(mark_o), 32'h21);
    tick(1);
    chk("R8 alternation", 32'(mark_o), 32'h22);

    guard_i = 4'b0001;
    init_i = 1'b1;
    tick(1);
    init_i = 1'b0;
    guard_i = 4'b0000;
    chk("R1 init beats firing", 32'(mark_o), 32'h11);
    chk("R7 debug after init", 32'(dbg_o), 32'h0);

    for (int i = 0; i < 400; i++) begin
      guard_i = 4'($urandom_range(0, 15));
      init_i  = ($urandom_range(0, 31) == 0);
      tick(1);
    end
    init_i = 1'b0;
    tick(1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule